// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block turns a digitized "supply below threshold" flag from an external comparator into a clean system reset. While the flag is raised, reset is held. Once the supply has been continuously good for a programmable number of clock cycles, reset is released. The nominal stretch is 200 ms, which is 20,000,000 cycles at 100 MHz. Any new low event during the stretch restarts the count, so short brown-out glitches make the reset longer.

The reset pin is open-drain. The block therefore drives only an output enable, `rstPinOe`, and a constant active level, `rstPinDrv`. A parameter selects the polarity: active-low or active-high.

In the active-low build, the pin readback also acts as a manual-reset input. The readback is synchronized and debounced first. It is ignored while the block is driving the pin, and for a few cycles after the block lets go.

A separate write-inhibit output protects an attached memory. It is raised while the supply is low, and from power-on until the supply is first seen above threshold.

Top module: `supv_reset_ctrl`

## Requirements
- R1: During and right after the power-on reset `rstN`, `rstPinOe` is 1 and `writeInhibit` is 1.
- R2: When `supplyLow` goes from 0 to 1 while the reset is released, `rstPinOe` rises on the third rising clock edge after the change and not earlier.
- R3: When `supplyLow` falls and then stays 0, `rstPinOe` falls on clock edge STRETCH_CYCLES+3 after the change and is still 1 on the edge before.
- R4: A `supplyLow` pulse during the stretch restarts the count. `rstPinOe` then falls STRETCH_CYCLES+1 edges after the synchronized pulse ends.
- R5: `rstPinDrv` is 0 when ACTIVE_LOW is 1 and is 1 when ACTIVE_LOW is 0.
- R6: While `rstPinOe` is 0, the block does not drive the pin. The bench models the pin as pulled to its idle level in that case.
- R7: In the active-low build, `rstPinIn`=0 held for DEBOUNCE_CYCLES synchronized samples while released raises `rstPinOe` on edge SYNC_STAGES+DEBOUNCE_CYCLES+1. It then runs a full stretch after the request clears.
- R8: In the active-low build, a `rstPinIn` low pulse shorter than DEBOUNCE_CYCLES cycles does not assert reset.
- R9: The pin readback is ignored while `rstPinOe` is 1 and for SYNC_STAGES+1 cycles after it falls. The block's own drive never re-triggers a reset.
- R10: In the active-high build, `rstPinIn` has no effect on `rstPinOe`.
- R11: `writeInhibit` follows the synchronized `supplyLow` one cycle later, on the third edge after a change. It is not raised by a manual reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| supplyLow | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| rstPinIn | input | 1 | Readback of the shared reset pin |
| rstPinOe | output | 1 | Open-drain drive enable; 1 = pull the pin to its active level |
| rstPinDrv | output | 1 | Level driven when enabled (the active level) |
| writeInhibit | output | 1 | 1 = block writes to the attached memory |

## Verification
The bench goes after exact release timing: a design that is off by one in the stretch counter releases reset one edge early or late. It injects a one-cycle supply glitch mid-stretch. A design that does not restart the count would release at the original time, and the bench checks that edge.

Manual pulses of exactly DEBOUNCE_CYCLES and of one cycle fewer separate a debounce that triggers too early from one that never triggers. After a manual reset, the bench watches the release. Missing readback masking would latch the block on its own drive and keep reset asserted forever. A second instance with active-high polarity proves the pin readback is ignored there.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } supvState_e;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } supvStrobe_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/supv_dp.sv
module supv_dp
  import supv_pkg::*;
#(
  parameter int ACTIVE_LOW      = 1,
  parameter int STRETCH_CYCLES  = 20_000_000,
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyLow,
  input  logic        rstPinIn,
  input  logic        pinOe,
  input  supvStrobe_t strobe,
  output logic        lowSync,
  output logic        manualReq,
  output logic        cntDone,
  output logic        writeInhibit
);

  localparam int   CNT_W     = $clog2(STRETCH_CYCLES);
  localparam int   DB_W      = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_CYCLES - 1);
  localparam logic [DB_W-1:0]  DB_MAX   = DB_W'(DEBOUNCE_CYCLES);
  localparam logic MANUAL_EN = (ACTIVE_LOW != 0);
  localparam logic PIN_IDLE  = (ACTIVE_LOW != 0);

  logic                 pinSync;
  logic                 pinActive;
  logic                 readMasked;
  logic [SYNC_STAGES:0] oeHist;
  logic [DB_W-1:0]      dbCnt;
  logic [CNT_W-1:0]     stretchCnt;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uLowSync (
    .clk(clk), .rstN(rstN), .din(supplyLow), .dout(lowSync)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) uPinSync (
    .clk(clk), .rstN(rstN), .din(rstPinIn), .dout(pinSync)
  );

  // Recent drive history covers the synchronizer latency after release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeHist <= '1;
    else       oeHist <= {oeHist[SYNC_STAGES-1:0], pinOe};
  end

  assign readMasked = pinOe | (|oeHist);
  assign pinActive  = MANUAL_EN & (pinSync != PIN_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        dbCnt <= '0;
    else if (!pinActive || readMasked) dbCnt <= '0;
    else if (dbCnt != DB_MAX)          dbCnt <= dbCnt + 1'b1;
  end

  assign manualReq = (dbCnt == DB_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stretchCnt <= '0;
    else if (strobe.cntClear) stretchCnt <= '0;
    else if (strobe.cntStep)  stretchCnt <= stretchCnt + 1'b1;
  end

  assign cntDone = (stretchCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) writeInhibit <= 1'b1;
    else       writeInhibit <= lowSync;
  end

  AST_MASK_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |=> (dbCnt == '0)); // R9
  AST_WI_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    lowSync |=> writeInhibit); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stretchCnt <= CNT_LAST); // R3

  generate
    if (ACTIVE_LOW == 0) begin : gNoManual
      AST_NO_MANUAL_HI: assert property (@(posedge clk) disable iff (!rstN)
        !manualReq); // R10
    end
  endgenerate

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowSync,
  input  logic        manualReq,
  input  logic        cntDone,
  output supvStrobe_t strobe,
  output logic        pinOe
);

  supvState_e state, nextState;
  logic       resetCond;

  assign resetCond = lowSync | manualReq;

  always_comb begin
    nextState       = state;
    strobe.cntClear = 1'b0;
    strobe.cntStep  = 1'b0;
    unique case (state)
      ST_HOLD: begin
        strobe.cntClear = 1'b1;
        if (!resetCond) nextState = ST_STRETCH;
      end
      ST_STRETCH: begin
        if (resetCond)    nextState = ST_HOLD;
        else if (cntDone) nextState = ST_RUN;
        else              strobe.cntStep = 1'b1;
      end
      ST_RUN: begin
        strobe.cntClear = 1'b1;
        if (resetCond) nextState = ST_HOLD;
      end
      default: nextState = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HOLD;
      pinOe <= 1'b1;
    end else begin
      state <= nextState;
      pinOe <= (nextState != ST_RUN);
    end
  end

  AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!rstN)
    lowSync |=> pinOe); // R2
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinOe) |-> $past(cntDone)); // R3
  AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    manualReq |=> pinOe); // R7

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int ACTIVE_LOW      = 1,
  parameter int STRETCH_CYCLES  = 20_000_000,
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic rstPinIn,
  output logic rstPinOe,
  output logic rstPinDrv,
  output logic writeInhibit
);

  localparam logic ACTIVE_LVL = (ACTIVE_LOW == 0);

  supvStrobe_t strobe;
  logic        lowSync;
  logic        manualReq;
  logic        cntDone;

  supv_dp #(
    .ACTIVE_LOW(ACTIVE_LOW), .STRETCH_CYCLES(STRETCH_CYCLES),
    .SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .rstPinIn(rstPinIn),
    .pinOe(rstPinOe), .strobe(strobe), .lowSync(lowSync),
    .manualReq(manualReq), .cntDone(cntDone), .writeInhibit(writeInhibit)
  );

  supv_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lowSync(lowSync), .manualReq(manualReq),
    .cntDone(cntDone), .strobe(strobe), .pinOe(rstPinOe)
  );

  assign rstPinDrv = ACTIVE_LVL;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (rstPinOe && writeInhibit)); // R1

endmodule

// File: tb/tb_supv_reset_ctrl.sv
module tb_supv_reset_ctrl;

  localparam int S   = 16;
  localparam int DEB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 1'b1;
  logic forceLo = 1'b0, forceHi = 1'b0;
  logic pinLo, pinHi;
  logic oeLo, drvLo, wiLo, oeHi, drvHi, wiHi;
  int   cycleCnt = 0;
  int   checks = 0, failures = 0;
  bit   finished = 1'b0;

  typedef struct {
    int    cyc;
    int    sel;
    int    fld;
    logic  exp;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t monItem;

  always #5 clk = ~clk;

  // Open-drain pins with pull to idle level
  assign pinLo = (oeLo | forceLo) ? 1'b0 : 1'b1;
  assign pinHi = (oeHi | forceHi) ? 1'b1 : 1'b0;

  supv_reset_ctrl #(.ACTIVE_LOW(1), .STRETCH_CYCLES(S), .SYNC_STAGES(2),
                    .DEBOUNCE_CYCLES(DEB)) dut (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .rstPinIn(pinLo),
    .rstPinOe(oeLo), .rstPinDrv(drvLo), .writeInhibit(wiLo));

  supv_reset_ctrl #(.ACTIVE_LOW(0), .STRETCH_CYCLES(S), .SYNC_STAGES(2),
                    .DEBOUNCE_CYCLES(DEB)) dutHi (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .rstPinIn(pinHi),
    .rstPinOe(oeHi), .rstPinDrv(drvHi), .writeInhibit(wiHi));

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycleCnt, act, exp);
    end
  endtask

  task automatic expectAt(input int cyc, input int sel, input int fld,
                          input logic exp, input string tag);
    exp_t it;
    it.cyc = cyc; it.sel = sel; it.fld = fld; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  function automatic logic pick(input int sel, input int fld);
    if (sel == 0) return (fld == 0) ? oeLo : wiLo;
    return (fld == 0) ? oeHi : wiHi;
  endfunction

  // Monitor: compare queued expectations in their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cycleCnt) begin
      monItem = q.pop_front();
      if (monItem.cyc < cycleCnt) begin
        checks++; failures++;
        $display("FAIL %s: expectation for cycle %0d missed", monItem.tag, monItem.cyc);
      end else begin
        check(pick(monItem.sel, monItem.fld), monItem.exp, monItem.tag);
      end
    end
  end

  always @(posedge clk) begin
    if (cycleCnt > 5000 && !finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    check(oeLo, 1'b1, "R1 oe in reset");
    check(wiLo, 1'b1, "R1 wi in reset");
    check(oeHi, 1'b1, "R1 oeHi in reset");
    check(drvLo, 1'b0, "R5 active-low drive level");
    check(drvHi, 1'b1, "R5 active-high drive level");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(oeLo, 1'b1, "R1 oe after reset");
    check(wiLo, 1'b1, "R11 wi before threshold first reached");

    // Power-up release
    b = cycleCnt; supplyLow = 1'b0;
    expectAt(b + 2, 0, 1, 1'b1, "R11 wi still high");
    expectAt(b + 3, 0, 1, 1'b0, "R11 wi falls");
    expectAt(b + S + 2, 0, 0, 1'b1, "R3 oe held before end");
    expectAt(b + S + 2, 1, 0, 1'b1, "R3 oeHi held before end");
    expectAt(b + S + 3, 0, 0, 1'b0, "R3 oe released");
    expectAt(b + S + 3, 1, 0, 1'b0, "R6 oeHi released");
    drain();
    repeat (4) @(negedge clk);

    // Brown-out from run
    b = cycleCnt; supplyLow = 1'b1;
    expectAt(b + 2, 0, 0, 1'b0, "R2 oe not early");
    expectAt(b + 3, 0, 0, 1'b1, "R2 oe asserted");
    expectAt(b + 3, 0, 1, 1'b1, "R11 wi on brown-out");
    drain();
    repeat (6) @(negedge clk);

    // Recovery with a glitch mid-stretch
    b = cycleCnt; supplyLow = 1'b0;
    expectAt(b + 11, 0, 1, 1'b1, "R11 wi on glitch");
    expectAt(b + 12, 0, 1, 1'b0, "R11 wi after glitch");
    expectAt(b + S + 3, 0, 0, 1'b1, "R4 no release at original time");
    expectAt(b + S + 11, 0, 0, 1'b1, "R4 held before restarted end");
    expectAt(b + S + 12, 0, 0, 1'b0, "R4 released after restart");
    repeat (8) @(negedge clk);
    supplyLow = 1'b1;
    @(negedge clk);
    supplyLow = 1'b0;
    drain();
    repeat (6) @(negedge clk);

    // Manual reset, active-low build
    b = cycleCnt; forceLo = 1'b1;
    expectAt(b + 2 + DEB, 0, 0, 1'b0, "R7 oe not early");
    expectAt(b + 3 + DEB, 0, 0, 1'b1, "R7 manual asserts");
    expectAt(b + 3 + DEB, 0, 1, 1'b0, "R11 manual does not inhibit");
    expectAt(b + 3 + DEB, 1, 0, 1'b0, "R10 other instance unaffected");
    expectAt(b + 5 + DEB + S - 1, 0, 0, 1'b1, "R7 stretch held");
    expectAt(b + 5 + DEB + S, 0, 0, 1'b0, "R7 stretch released");
    expectAt(b + 11 + DEB + S, 0, 0, 1'b0, "R9 own drive no retrigger");
    repeat (10) @(negedge clk);
    forceLo = 1'b0;
    drain();
    repeat (6) @(negedge clk);

    // Short pulse, one below debounce
    b = cycleCnt; forceLo = 1'b1;
    expectAt(b + 6, 0, 0, 1'b0, "R8 short pulse ignored");
    expectAt(b + 9, 0, 0, 1'b0, "R8 still released");
    repeat (DEB - 1) @(negedge clk);
    forceLo = 1'b0;
    drain();
    repeat (4) @(negedge clk);

    // Pulse exactly at debounce length
    b = cycleCnt; forceLo = 1'b1;
    expectAt(b + 2 + DEB, 0, 0, 1'b0, "R7 boundary not early");
    expectAt(b + 3 + DEB, 0, 0, 1'b1, "R7 boundary pulse triggers");
    expectAt(b + 5 + DEB + S, 0, 0, 1'b0, "R9 boundary release");
    repeat (DEB) @(negedge clk);
    forceLo = 1'b0;
    drain();
    repeat (6) @(negedge clk);

    // Active-high build ignores readback
    b = cycleCnt; forceHi = 1'b1;
    expectAt(b + 8, 1, 0, 1'b0, "R10 readback ignored");
    expectAt(b + 12, 1, 0, 1'b0, "R10 still released");
    drain();
    forceHi = 1'b0;
    @(negedge clk);
    check(oeLo, 1'b0, "R6 active-low released at end");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule